// File: doc/BRIEF.md
# Split-Operand Signed-by-Unsigned Multiplier

This block multiplies a signed operand of up to 18 bits by an unsigned 34-bit operand. It uses two 18x18 signed multipliers and one adder. The unsigned operand is cut into a lower and an upper 17-bit half. A zero is placed above each half, so every multiplier input coming from the unsigned operand is seen as non-negative. The signed operand goes unchanged into both multipliers.

The upper-half product carries a weight of 2^17. It is added to the lower-half product with that offset. The 17 least significant bits of the lower-half product already are the final low bits of the result, so they skip the adder. The adder then only needs to cover the upper 35 bits.

The 52-bit signed result is registered once and comes with a valid flag. A wide multiplier can use this block as a building tile where one segment is signed and short and the other is long and unsigned.

Top module: `split_pp_mul`

## Requirements
- R1: While rst_ni is low, and after its release until the first accepted operand pair, valid_o is 0 and prod_o is all zeros.
- R2: valid_o equals the value valid_i had at the previous rising clock edge.
- R3: When valid_i is 1 at a rising edge, prod_o after that edge equals the two's-complement product of sgn_i (signed, 18 bits, bit 17 is the sign) and uns_i (unsigned, 34 bits), as a 52-bit signed value.
- R4: When valid_i is 0 at a rising edge, prod_o keeps its previous value whatever sgn_i and uns_i hold.
- R5: prod_o[16:0] depends only on sgn_i and uns_i[16:0]. Changing uns_i[33:17] alone leaves those 17 bits unchanged.
- R6: The result is exact at the signed extremes, including sgn_i = -131072 with uns_i = 2^34-1, and sgn_i = 131071 with uns_i = 2^34-1.
- R7: The result is exact when either half of uns_i is zero, and when uns_i has exactly one bit set on either side of the 17-bit split (bit 16 or bit 17).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair is present this cycle |
| sgn_i | input | 18 | Signed operand, two's complement |
| uns_i | input | 34 | Unsigned operand |
| valid_o | output | 1 | prod_o holds a fresh result |
| prod_o | output | 52 | Signed product, registered |

## Verification
The hardest case to reach is the join at bit 17. Here the lower-half product is negative and has bits above position 16. Those bits must sign-extend and merge correctly with a large upper-half product. Random operands almost never land on the most negative signed value against an all-ones unsigned operand, and they rarely isolate one half of the unsigned operand.

The stimulus therefore sweeps a fixed set of signed extremes and small values. It crosses each one with directed unsigned patterns that load only one half, set single bits next to the split, or set every bit. Random unsigned values are added on top. A separate pass changes only the upper half of the unsigned operand, to show that the bypassed low bits stay unaffected.

// File: rtl/split_pp_pkg.sv
package split_pp_pkg;
  localparam int unsigned NATIVE_MUL_W = 18;
  localparam int unsigned NUM_HALVES   = 2;
endpackage

// File: rtl/half_mul.sv
module half_mul #(
  parameter int unsigned MUL_W = 18
) (
  input  logic signed [MUL_W-1:0]   a_i,
  input  logic        [MUL_W-2:0]   mag_i,
  output logic signed [2*MUL_W-1:0] p_o
);
  logic signed [MUL_W-1:0] b_pos;

  // sign bit tied low: unsigned half looks positive to the signed multiplier
  assign b_pos = $signed({1'b0, mag_i});
  assign p_o   = a_i * b_pos;

  always_comb begin
    if (a_i != '0 && mag_i != '0)
      p_sign_r3: assert (p_o[2*MUL_W-1] == a_i[MUL_W-1])
        else $error("half product sign disagrees with signed operand");
  end
endmodule

// File: rtl/split_sum.sv
module split_sum #(
  parameter int unsigned HALF_W = 17,
  parameter int unsigned PP_W   = 36,
  parameter int unsigned PROD_W = 52
) (
  input  logic signed [PP_W-1:0]   lo_i,
  input  logic signed [PP_W-1:0]   hi_i,
  output logic        [PROD_W-1:0] sum_o
);
  localparam int unsigned UP_W  = PROD_W - HALF_W;
  localparam int unsigned LSH_W = PP_W - HALF_W;

  logic signed [UP_W:0] hi_ext;
  logic signed [UP_W:0] lo_ext;
  logic signed [UP_W:0] up_sum;

  assign hi_ext = $signed({hi_i[UP_W-1], hi_i[UP_W-1:0]});
  assign lo_ext = $signed({{(UP_W+1-LSH_W){lo_i[PP_W-1]}}, lo_i[PP_W-1:HALF_W]});
  assign up_sum = hi_ext + lo_ext;

  // low bits bypass the adder
  assign sum_o  = {up_sum[UP_W-1:0], lo_i[HALF_W-1:0]};

  always_comb begin
    p_no_overflow_r3: assert (up_sum[UP_W] == up_sum[UP_W-1])
      else $error("upper sum exceeds result width");
  end
endmodule

// File: rtl/split_pp_mul.sv
module split_pp_mul
  import split_pp_pkg::*;
#(
  parameter int unsigned SGN_W  = 18,
  parameter int unsigned HALF_W = 17
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [SGN_W-1:0]          sgn_i,
  input  logic [2*HALF_W-1:0]       uns_i,
  output logic                      valid_o,
  output logic [SGN_W+2*HALF_W-1:0] prod_o
);
  localparam int unsigned UNS_W  = 2 * HALF_W;
  localparam int unsigned MUL_W  = HALF_W + 1;
  localparam int unsigned PP_W   = 2 * MUL_W;
  localparam int unsigned PROD_W = SGN_W + UNS_W;

  logic signed [MUL_W-1:0] a_ext;
  logic signed [PP_W-1:0]  pp [NUM_HALVES];
  logic        [PROD_W-1:0] sum;

  generate
    if (SGN_W == MUL_W) begin : g_a_direct
      assign a_ext = $signed(sgn_i);
    end else begin : g_a_sext
      assign a_ext = $signed({{(MUL_W-SGN_W){sgn_i[SGN_W-1]}}, sgn_i});
    end
  endgenerate

  generate
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
      half_mul #(.MUL_W(MUL_W)) u_mul (
        .a_i  (a_ext),
        .mag_i(uns_i[h*HALF_W +: HALF_W]),
        .p_o  (pp[h])
      );
    end
  endgenerate

  split_sum #(.HALF_W(HALF_W), .PP_W(PP_W), .PROD_W(PROD_W)) u_sum (
    .lo_i (pp[0]),
    .hi_i (pp[1]),
    .sum_o(sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      prod_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) prod_o <= sum;
    end
  end

  logic [PROD_W-1:0] ref_prod;
  assign ref_prod = $signed({{UNS_W{sgn_i[SGN_W-1]}}, sgn_i}) * $signed({{SGN_W{1'b0}}, uns_i});

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(valid_i))
    else $error("valid_o latency wrong");

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(prod_o))
    else $error("prod_o changed without valid_i");

  p_product_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> prod_o == $past(ref_prod))
    else $error("prod_o differs from native product");
endmodule

// File: tb/tb_split_pp_mul.sv
module tb_split_pp_mul;
  localparam int SW = 18;
  localparam int UW = 34;
  localparam int PW = 52;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [SW-1:0] sgn_i = '0;
  logic [UW-1:0] uns_i = '0;
  logic          valid_o;
  logic [PW-1:0] prod_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  split_pp_mul dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .sgn_i(sgn_i), .uns_i(uns_i), .valid_o(valid_o), .prod_o(prod_o)
  );

  function automatic logic [PW-1:0] expect_prod(longint a, longint b);
    return PW'(a * b);
  endfunction

  task automatic check(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_one(string req, longint a, longint b);
    sgn_i   = SW'(a);
    uns_i   = UW'(b);
    valid_i = 1'b1;
    @(negedge clk_i);
    check(req, prod_o, expect_prod(a, b));
    check("R2", {51'd0, valid_o}, 52'd1);
  endtask

  longint a_set [8] = '{-131072, -131071, -2, -1, 0, 1, 65535, 131071};
  longint b_set [8] = '{0, 1, 64'h1FFFF, 64'h20000, 64'h10000, 64'h3FFFE0000,
                        64'h3FFFFFFFF, 64'h2AAAA5555};

  initial begin
    repeat (50000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [PW-1:0] held;
    logic [16:0]   low_ref;
    repeat (3) @(negedge clk_i);
    // R1: values during reset
    check("R1", prod_o, '0);
    check("R1", {51'd0, valid_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", prod_o, '0);
    check("R1", {51'd0, valid_o}, '0);

    // R6/R7: extremes crossed with directed patterns
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        run_one((i == 0 || i == 7) ? "R6" : "R7", a_set[i], b_set[j]);
    // R3: random unsigned values against every signed extreme
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 16; k++)
        run_one("R3", a_set[i], longint'({$urandom, $urandom} & 64'h3FFFFFFFF));
    // R3: random on both sides
    for (int k = 0; k < 64; k++)
      run_one("R3", longint'($signed(SW'($urandom))),
              longint'({$urandom, $urandom} & 64'h3FFFFFFFF));

    // R4: hold while valid_i low
    run_one("R3", -131072, 64'h3FFFFFFFF);
    held = prod_o;
    for (int k = 0; k < 4; k++) begin
      valid_i = 1'b0;
      sgn_i   = SW'($urandom);
      uns_i   = UW'({$urandom, $urandom});
      @(negedge clk_i);
      check("R4", prod_o, held);
      check("R2", {51'd0, valid_o}, '0);
    end

    // R5: upper half changes leave low 17 bits alone
    for (int i = 0; i < 8; i++) begin
      low_ref = 17'(a_set[i] * 64'h15A5A);
      for (int k = 0; k < 4; k++) begin
        sgn_i   = SW'(a_set[i]);
        uns_i   = {17'($urandom), 17'h15A5A};
        valid_i = 1'b1;
        @(negedge clk_i);
        check("R5", {35'd0, prod_o[16:0]}, {35'd0, low_ref});
      end
    end
    valid_i = 1'b0;
    @(negedge clk_i);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule